// File: doc/BRIEF.md
# HDLC Test Control and FIFO Path Router

This block sits between an HDLC controller's host port, its transmit and receive FIFOs and its serial framer. It holds one 8-bit test-control byte and uses it to steer every FIFO write and read strobe, the tag bits that travel with each byte, and the serial receive input. The FIFOs and the framer lie outside the block. All routing is combinational, so a strobe presented on an input reaches the selected FIFO in the same cycle. Only the control byte is stored in flops.

The control byte has four live fields. Bit 7 is a sticky soft reset that holds the controller in reset. Bit 6 copies received data into the transmit FIFO as well as the receive FIFO. Bit 2 is a FIFO test mode that swaps which FIFO the host writes and reads. Bit 0 routes the serial transmit bit back to the receive input. Bits 5, 4, 3 and 1 are reserved. A one written to bit 7 takes effect at once. Clearing the bit needs an unbroken run of zero writes, two by default. When both a host write and a receive-path write aim at the same FIFO in one cycle, the receive path wins.

Top module: `hdlc_test_router`

## Requirements
- R1: After hardware reset the control byte reads 0x00, and `hdlc_rst` is high while `rst_n` is low.
- R2: A write with bit 7 set sets the soft reset, which drives `hdlc_rst` high. The soft reset stays set through any single zero write that follows.
- R3: The soft reset clears only after two consecutive writes with bit 7 clear. A write with bit 7 set in between restarts the count.
- R4: Bits 6..0 read back as last written. Bit 7 reads back the soft-reset state.
- R5: Outside soft reset, every valid received byte is written to the RX FIFO with its tag.
- R6: With bit 6 set, every valid received byte not marked as flag/CRC overhead is also written to the TX FIFO with its tag. Overhead bytes are never copied.
- R7: With bit 2 set, a host TX-FIFO write becomes an RX-FIFO write carrying the host data and tag. With bit 2 clear, it goes to the TX FIFO.
- R8: With bit 2 set, a host RX-FIFO read becomes a TX-FIFO read and `host_rtag` returns the TX FIFO output tag. With bit 2 clear, the read goes to the RX FIFO and `host_rtag` returns the RX FIFO output tag.
- R9: `ser_rx_out` follows `ser_tx_bit` only when bit 0, `rx_en` and `tx_en` are all set. Otherwise it follows `ser_rx_line`.
- R10: Reserved bits 5, 4, 3 and 1 have no effect on any routing.
- R11: While the soft reset is set, no FIFO write strobe is asserted.
- R12: If the receive path and the host write the same FIFO in one cycle, only the receive-path byte and tag are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| hdlc_rst | output | 1 | Controller reset (hardware or soft) |
| host_wr | input | 1 | Host write to the TX FIFO |
| host_wdata | input | DATA_W | Host write data |
| host_wtag | input | TAG_W | Host write tag bits |
| host_rd | input | 1 | Host read of the RX FIFO |
| host_rtag | output | TAG_W | Tag bits returned to the host |
| rx_vld | input | 1 | Received byte valid |
| rx_byte | input | DATA_W | Received byte |
| rx_tag | input | TAG_W | Received byte tag (end of packet / abort) |
| rx_ovhd | input | 1 | Received byte is flag or CRC overhead |
| rxf_wr | output | 1 | RX FIFO write strobe |
| rxf_wdata | output | DATA_W | RX FIFO write data |
| rxf_wtag | output | TAG_W | RX FIFO write tag |
| rxf_rd | output | 1 | RX FIFO read strobe |
| rxf_rtag | input | TAG_W | RX FIFO output tag |
| txf_wr | output | 1 | TX FIFO write strobe |
| txf_wdata | output | DATA_W | TX FIFO write data |
| txf_wtag | output | TAG_W | TX FIFO write tag |
| txf_rd | output | 1 | TX FIFO read strobe |
| txf_rtag | input | TAG_W | TX FIFO output tag |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| ser_tx_bit | input | 1 | Serial transmit bit from the framer |
| ser_rx_line | input | 1 | Serial receive bit from the line |
| ser_rx_out | output | 1 | Serial receive bit to the framer |

## Verification
The hardest state to reach is a soft reset that has seen part of its zero-write run and is then disturbed. From the ports it looks exactly like a fresh soft reset, so its cause shows only in how many further writes are needed to clear it. The stimulus sets the soft reset, writes one zero, writes a one, then writes zeros one at a time and reads bit 7 back after each write. This shows that the run restarted. Routing is covered by sweeping every combination of the two path-mode bits, the reserved bits and the four receive/host strobes. A separate sweep covers every combination of serial loopback, the two enables and the two serial levels.

// File: rtl/htr_pkg.sv
package htr_pkg;
   localparam int CTL_W    = 8;
   localparam int B_SRST   = 7;
   localparam int B_R2T    = 6;
   localparam int B_FTST   = 2;
   localparam int B_T2R    = 0;

   typedef struct packed {
      logic srst;
      logic r2t;
      logic ftst;
      logic t2r;
   } ctl_t;
endpackage

// File: rtl/htr_ctrl_reg.sv
module htr_ctrl_reg
   import htr_pkg::*;
#(
   parameter int ZERO_WRITES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] rdata,
   output ctl_t             ctl
);
   localparam int CW = (ZERO_WRITES > 1) ? $clog2(ZERO_WRITES) : 1;
   localparam logic [CW-1:0] LAST = CW'(ZERO_WRITES - 1);

   initial begin
      if (ZERO_WRITES < 1) $error("ZERO_WRITES must be at least 1");
   end

   logic             srst_q;
   logic [CTL_W-2:0] low_q;
   logic [CW-1:0]    zcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         low_q  <= '0;
         zcnt_q <= '0;
      end else if (wr) begin
         low_q <= wdata[CTL_W-2:0];
         if (wdata[B_SRST]) begin
            srst_q <= 1'b1;
            zcnt_q <= '0;
         end else if (srst_q) begin
            if (zcnt_q == LAST) begin
               srst_q <= 1'b0;
               zcnt_q <= '0;
            end else begin
               zcnt_q <= zcnt_q + 1'b1;
            end
         end
      end
   end

   assign rdata    = {srst_q, low_q};
   assign ctl.srst = srst_q;
   assign ctl.r2t  = low_q[B_R2T];
   assign ctl.ftst = low_q[B_FTST];
   assign ctl.t2r  = low_q[B_T2R];

   // R2: a write of one always leaves the soft reset set
   a_r2_one_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[B_SRST]) |=> srst_q);

   // R3: soft reset only falls right after a zero write
   a_r3_fall_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(srst_q) |-> $past(wr && !wdata[B_SRST]));

   generate
      if (ZERO_WRITES > 1) begin : g_multi
         // R3: the first zero write of a run does not clear
         a_r3_first_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (srst_q && wr && !wdata[B_SRST] && zcnt_q == '0) |=> srst_q);
      end
   endgenerate
endmodule

// File: rtl/htr_rx_route.sv
module htr_rx_route
   import htr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  ctl_t ctl,
   input  logic rx_vld,
   input  logic rx_ovhd,
   output logic rx_wr,
   output logic cp_wr
);
   assign rx_wr = rx_vld && !ctl.srst;
   assign cp_wr = rx_vld && !rx_ovhd && ctl.r2t && !ctl.srst;

   // R6: overhead bytes never produce a transmit copy
   a_r6_no_ovhd_copy: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovhd |-> !cp_wr);
   // R6: a copy always comes with the matching receive write
   a_r6_copy_implies_rx: assert property (@(posedge clk) disable iff (!rst_n)
      cp_wr |-> rx_wr);
endmodule

// File: rtl/htr_host_swap.sv
module htr_host_swap
   import htr_pkg::*;
#(
   parameter int TAG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctl_t             ctl,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [TAG_W-1:0] rxf_rtag,
   input  logic [TAG_W-1:0] txf_rtag,
   output logic             h_rxf_wr,
   output logic             h_txf_wr,
   output logic             rxf_rd,
   output logic             txf_rd,
   output logic [TAG_W-1:0] host_rtag
);
   logic h_wr_ok;
   assign h_wr_ok   = host_wr && !ctl.srst;
   assign h_rxf_wr  = h_wr_ok && ctl.ftst;
   assign h_txf_wr  = h_wr_ok && !ctl.ftst;
   assign txf_rd    = host_rd && ctl.ftst;
   assign rxf_rd    = host_rd && !ctl.ftst;
   assign host_rtag = ctl.ftst ? txf_rtag : rxf_rtag;

   // R8: a host read reaches at most one FIFO
   a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rxf_rd, txf_rd}) <= 1);
   // R7: a host write reaches at most one FIFO
   a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({h_rxf_wr, h_txf_wr}));
endmodule

// File: rtl/hdlc_test_router.sv
module hdlc_test_router
   import htr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TAG_W       = 2,
   parameter int ZERO_WRITES = 2,
   parameter bit REG_SER     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic              hdlc_rst,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [TAG_W-1:0]  host_wtag,
   input  logic              host_rd,
   output logic [TAG_W-1:0]  host_rtag,
   input  logic              rx_vld,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [TAG_W-1:0]  rx_tag,
   input  logic              rx_ovhd,
   output logic              rxf_wr,
   output logic [DATA_W-1:0] rxf_wdata,
   output logic [TAG_W-1:0]  rxf_wtag,
   output logic              rxf_rd,
   input  logic [TAG_W-1:0]  rxf_rtag,
   output logic              txf_wr,
   output logic [DATA_W-1:0] txf_wdata,
   output logic [TAG_W-1:0]  txf_wtag,
   output logic              txf_rd,
   input  logic [TAG_W-1:0]  txf_rtag,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic              ser_tx_bit,
   input  logic              ser_rx_line,
   output logic              ser_rx_out
);
   initial begin
      if (DATA_W < 1) $error("DATA_W must be at least 1");
      if (TAG_W < 1)  $error("TAG_W must be at least 1");
   end

   ctl_t ctl;
   logic rx_wr, cp_wr, h_rxf_wr, h_txf_wr;

   htr_ctrl_reg #(.ZERO_WRITES(ZERO_WRITES)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
      .rdata(ctl_rdata), .ctl(ctl));

   htr_rx_route u_rx (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .rx_vld(rx_vld),
      .rx_ovhd(rx_ovhd), .rx_wr(rx_wr), .cp_wr(cp_wr));

   htr_host_swap #(.TAG_W(TAG_W)) u_host (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .host_wr(host_wr),
      .host_rd(host_rd), .rxf_rtag(rxf_rtag), .txf_rtag(txf_rtag),
      .h_rxf_wr(h_rxf_wr), .h_txf_wr(h_txf_wr), .rxf_rd(rxf_rd),
      .txf_rd(txf_rd), .host_rtag(host_rtag));

   assign hdlc_rst = !rst_n || ctl.srst;

   // receive path has priority over the host on each FIFO
   assign rxf_wr    = rx_wr || h_rxf_wr;
   assign rxf_wdata = rx_wr ? rx_byte : host_wdata;
   assign rxf_wtag  = rx_wr ? rx_tag  : host_wtag;
   assign txf_wr    = cp_wr || h_txf_wr;
   assign txf_wdata = cp_wr ? rx_byte : host_wdata;
   assign txf_wtag  = cp_wr ? rx_tag  : host_wtag;

   logic ser_lb;
   assign ser_lb = ctl.t2r && rx_en && tx_en;

   generate
      if (REG_SER) begin : g_ser_reg
         logic ser_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ser_q <= 1'b0;
            else        ser_q <= ser_lb ? ser_tx_bit : ser_rx_line;
         end
         assign ser_rx_out = ser_q;
      end else begin : g_ser_comb
         assign ser_rx_out = ser_lb ? ser_tx_bit : ser_rx_line;
         // R9: without all three enables the line passes straight through
         a_r9_line_through: assert property (@(posedge clk) disable iff (!rst_n)
            !(ctl.t2r && rx_en && tx_en) |-> (ser_rx_out == ser_rx_line));
      end
   endgenerate

   // R11: no FIFO write while the soft reset holds
   a_r11_quiet_in_srst: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[B_SRST] |-> (!rxf_wr && !txf_wr));
   // R12: a received byte always owns the RX FIFO write port
   a_r12_rx_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld && !hdlc_rst) |-> (rxf_wr && rxf_wdata == rx_byte && rxf_wtag == rx_tag));
   // R2: soft reset drives the controller reset
   a_r2_rst_out: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[B_SRST] |-> hdlc_rst);
endmodule

// File: tb/hdlc_test_router_tb_top.sv
module hdlc_test_router_tb_top;
   localparam int DW = 8;
   localparam int TW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic hdlc_rst;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic [TW-1:0] host_wtag = '0, host_rtag;
   logic rx_vld = 1'b0, rx_ovhd = 1'b0;
   logic [DW-1:0] rx_byte = '0;
   logic [TW-1:0] rx_tag = '0;
   logic rxf_wr, rxf_rd, txf_wr, txf_rd;
   logic [DW-1:0] rxf_wdata, txf_wdata;
   logic [TW-1:0] rxf_wtag, txf_wtag;
   logic [TW-1:0] rxf_rtag = 2'b01, txf_rtag = 2'b11;
   logic rx_en = 1'b0, tx_en = 1'b0, ser_tx_bit = 1'b0, ser_rx_line = 1'b0;
   logic ser_rx_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   hdlc_test_router dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .hdlc_rst(hdlc_rst), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_wtag(host_wtag), .host_rd(host_rd),
      .host_rtag(host_rtag), .rx_vld(rx_vld), .rx_byte(rx_byte),
      .rx_tag(rx_tag), .rx_ovhd(rx_ovhd), .rxf_wr(rxf_wr),
      .rxf_wdata(rxf_wdata), .rxf_wtag(rxf_wtag), .rxf_rd(rxf_rd),
      .rxf_rtag(rxf_rtag), .txf_wr(txf_wr), .txf_wdata(txf_wdata),
      .txf_wtag(txf_wtag), .txf_rd(txf_rd), .txf_rtag(txf_rtag),
      .rx_en(rx_en), .tx_en(tx_en), .ser_tx_bit(ser_tx_bit),
      .ser_rx_line(ser_rx_line), .ser_rx_out(ser_rx_out));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
      #1;
   endtask

   initial begin
      #900000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1;
      check("R1 rst out during reset", 32'(hdlc_rst), 32'd1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset readback", 32'(ctl_rdata), 32'h00);
      check("R1 rst out released", 32'(hdlc_rst), 32'd0);

      // R4 readback
      wr_ctl(8'h45);
      check("R4 readback low bits", 32'(ctl_rdata), 32'h45);

      // routing sweep: m[0]=ftst, m[1]=r2t, m[2]=reserved bits set
      for (int m = 0; m < 8; m++) begin
         wr_ctl({1'b0, m[1], m[2], m[2], m[2], m[0], m[2], 1'b0});
         for (int v = 0; v < 16; v++) begin
            logic rw, cp, hw, ft, e_rxw, e_txw;
            logic [DW-1:0] e_rxd, e_txd;
            logic [TW-1:0] e_rxt, e_txt;
            @(negedge clk);
            rx_vld = v[0]; rx_ovhd = v[1]; host_wr = v[2]; host_rd = v[3];
            rx_byte = 8'(8'hA0 + v); host_wdata = 8'(8'h50 + v + m);
            rx_tag = 2'(v); host_wtag = 2'(m + 2);
            #1;
            ft = m[0]; rw = v[0]; hw = v[2];
            cp = v[0] && !v[1] && m[1];
            e_rxw = rw || (hw && ft);
            e_rxd = rw ? rx_byte : host_wdata;
            e_rxt = rw ? rx_tag : host_wtag;
            e_txw = cp || (hw && !ft);
            e_txd = cp ? rx_byte : host_wdata;
            e_txt = cp ? rx_tag : host_wtag;
            check("R5 R7 R10 R12 rx fifo write", {22'd0, rxf_wr, rxf_wdata, 1'b0, rxf_wtag},
                  {22'd0, e_rxw, e_rxd, 1'b0, e_rxt});
            check("R6 R7 R10 R12 tx fifo write", {22'd0, txf_wr, txf_wdata, 1'b0, txf_wtag},
                  {22'd0, e_txw, e_txd, 1'b0, e_txt});
            check("R8 R10 read swap", {27'd0, rxf_rd, txf_rd, 1'b0, host_rtag},
                  {27'd0, v[3] && !ft, v[3] && ft, 1'b0, ft ? txf_rtag : rxf_rtag});
         end
      end
      @(negedge clk);
      rx_vld = 0; host_wr = 0; host_rd = 0; rx_ovhd = 0;

      // soft reset: set with both path modes, then stimulate
      wr_ctl(8'hC4);
      check("R2 soft reset set", 32'(ctl_rdata), 32'hC4);
      check("R2 rst out", 32'(hdlc_rst), 32'd1);
      @(negedge clk);
      rx_vld = 1; host_wr = 1; #1;
      check("R11 no writes in soft reset", {30'd0, rxf_wr, txf_wr}, 32'd0);
      @(negedge clk);
      rx_vld = 0; host_wr = 0;
      wr_ctl(8'h00);
      check("R2 single zero keeps", 32'(ctl_rdata[7]), 32'd1);
      wr_ctl(8'h80);
      check("R3 one write restarts", 32'(ctl_rdata[7]), 32'd1);
      wr_ctl(8'h00);
      check("R3 first zero after restart", 32'(ctl_rdata[7]), 32'd1);
      wr_ctl(8'h00);
      check("R3 second zero clears", 32'(ctl_rdata), 32'h00);
      check("R3 rst out cleared", 32'(hdlc_rst), 32'd0);
      @(negedge clk);
      rx_vld = 1; #1;
      check("R5 writes resume", 32'(rxf_wr), 32'd1);
      @(negedge clk);
      rx_vld = 0;

      // hardware reset clears soft reset
      wr_ctl(8'h80);
      @(negedge clk);
      rst_n = 0; #1;
      check("R1 hw reset readback", 32'(ctl_rdata), 32'h00);
      @(negedge clk);
      rst_n = 1; #1;
      check("R1 rst out after hw reset", 32'(hdlc_rst), 32'd0);

      // serial loopback sweep
      for (int lb = 0; lb < 2; lb++) begin
         wr_ctl({7'd0, lb[0]});
         for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            rx_en = s[0]; tx_en = s[1]; ser_tx_bit = s[2]; ser_rx_line = s[3];
            #1;
            check("R9 serial select", 32'(ser_rx_out),
                  32'((lb[0] && s[0] && s[1]) ? s[2] : s[3]));
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule